// File: doc/BRIEF.md
# Eight-Level Priority Interrupt Controller

This block sits between a set of peripheral interrupt sources and a processor core. Each maskable source owns an enable bit and a 3-bit priority. An event on an enabled source sets a pending flag. The controller selects the highest-priority pending source and compares its level with the core's 3-bit mask field.

When the winner is strictly above the mask and the core signals an instruction boundary, the controller issues a one-cycle acceptance. The acceptance carries a vector number, the mask level the core must write back, and a pulse that clears the core's trace bit. A separate non-maskable input is captured on its rising edge. It outranks every maskable source and ignores the mask.

Stacking of state, the vector-table fetch and handler execution belong to the core. The block models them only as the accept handshake.

Top module: `prio_irq_ctrl`

## Requirements
- R1: A source's pending flag is set only by an event while its enable bit is 1; an event on a disabled source is ignored and never produces an acceptance.
- R2: A maskable pending flag stays set until software acknowledges that source or its enable drops to 0; acceptance alone does not clear it, and acknowledge wins over a simultaneous event.
- R3: Among pending maskable sources, the one with the numerically largest priority (0 lowest, 7 highest) is selected.
- R4: When several pending sources share the highest priority, the lowest source index wins.
- R5: A maskable request is accepted only when its priority is strictly greater than the mask level; at or below the mask it stays pending and is accepted once the mask is lowered.
- R6: A rising edge on the non-maskable input sets a non-maskable pending flag. That flag beats every maskable source, is accepted whatever the mask, and is cleared by its own acceptance.
- R7: `accept` rises only in the cycle after a cycle with `insn_done` high and an acceptable request, lasts one cycle, and never occurs in two consecutive cycles.
- R8: With `accept`, `new_mask` equals the accepted source's priority, or 7 for the non-maskable input.
- R9: With `accept`, `trace_clr` is 1 and `acc_vec` is VEC_BASE + k for maskable source k (default base 16) or NMI_VEC (default 8) for the non-maskable input. With `accept` low, `trace_clr`, `acc_vec`, `new_mask` and `acc_nmi` are all 0.
- R10: After reset, nothing is pending and all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_event | input | NSRC | Per-source event strobe |
| src_en | input | NSRC | Per-source enable |
| src_ack | input | NSRC | Per-source software acknowledge (clears pending) |
| src_prio | input | 3*NSRC | Packed priorities, source k in bits [3k+2:3k] |
| nmi_in | input | 1 | Non-maskable input, edge-captured |
| mask_lvl | input | 3 | Current mask level from the core status |
| insn_done | input | 1 | Instruction-boundary strobe |
| accept | output | 1 | One-cycle acceptance pulse |
| acc_nmi | output | 1 | Accepted request is the non-maskable input |
| acc_vec | output | VEC_W | Vector number of the accepted request |
| new_mask | output | 3 | Mask level the core must write back |
| trace_clr | output | 1 | Pulse clearing the core's trace bit |

## Verification
Directed sequences separate the selection rules. Two sources at different levels show the level ordering. Two sources at equal level show the index tiebreak. A request held at the mask level, then released by lowering the mask, shows strict comparison and that a pending flag survives. A non-maskable edge under mask 7 shows the bypass and the forced mask. A boundary strobe held high for two cycles shows that acceptances are never back to back. Seeded random traffic then mixes events, acknowledges, enable changes, mask moves and boundary strobes, and compares every output cycle against a bench model.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int LVL_W = 3;
  typedef logic [LVL_W-1:0] lvl_t;
  localparam lvl_t LVL_TOP = 3'd7;
endpackage

// File: rtl/irqc_pending.sv
module irqc_pending #(
  parameter int NSRC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_event,
  input  logic [NSRC-1:0] src_en,
  input  logic [NSRC-1:0] src_ack,
  output logic [NSRC-1:0] pend
);
  logic [NSRC-1:0] pend_nx;

  for (genvar k = 0; k < NSRC; k++) begin : g_src
    always_comb begin
      if (src_ack[k] || !src_en[k])
        pend_nx[k] = 1'b0;
      else
        pend_nx[k] = pend[k] | src_event[k];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend[k] <= 1'b0;
      else        pend[k] <= pend_nx[k];
    end

    // R1: a flag only rises after an enabled event
    a_r1_set_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend[k]) |-> $past(src_event[k] && src_en[k]));
    // R2: a flag persists without acknowledge and with enable
    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (pend[k] && !src_ack[k] && src_en[k]) |=> pend[k]);
  end
endmodule

// File: rtl/irqc_nmi_edge.sv
module irqc_nmi_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_in,
  input  logic nmi_taken,
  output logic nmi_pend
);
  logic nmi_q;
  logic pend_nx;
  logic edge_seen;

  always_comb begin
    edge_seen = nmi_in & ~nmi_q;
    pend_nx   = edge_seen | (nmi_pend & ~nmi_taken);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_q    <= 1'b0;
      nmi_pend <= 1'b0;
    end else begin
      nmi_q    <= nmi_in;
      nmi_pend <= pend_nx;
    end
  end

  // R6: flag held until taken
  a_r6_nmi_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_pend && !nmi_taken) |=> nmi_pend);
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter
  import irqc_pkg::*;
#(
  parameter int NSRC = 8,
  localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0]       pend,
  input  logic [LVL_W*NSRC-1:0] prio,
  output logic                  found,
  output logic [IDX_W-1:0]      win_idx,
  output lvl_t                  win_lvl
);
  always_comb begin
    found   = 1'b0;
    win_idx = '0;
    win_lvl = '0;
    // descending scan, >= lets lower index take equal-level ties
    for (int k = NSRC - 1; k >= 0; k--) begin
      if (pend[k] && (!found || prio[LVL_W*k +: LVL_W] >= win_lvl)) begin
        found   = 1'b1;
        win_idx = IDX_W'(k);
        win_lvl = prio[LVL_W*k +: LVL_W];
      end
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import irqc_pkg::*;
#(
  parameter int NSRC     = 8,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 16,
  parameter int NMI_VEC  = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NSRC-1:0]       src_event,
  input  logic [NSRC-1:0]       src_en,
  input  logic [NSRC-1:0]       src_ack,
  input  logic [LVL_W*NSRC-1:0] src_prio,
  input  logic                  nmi_in,
  input  logic [LVL_W-1:0]      mask_lvl,
  input  logic                  insn_done,
  output logic                  accept,
  output logic                  acc_nmi,
  output logic [VEC_W-1:0]      acc_vec,
  output logic [LVL_W-1:0]      new_mask,
  output logic                  trace_clr
);
  localparam int IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam logic [VEC_W-1:0] BASE_V = VEC_W'(VEC_BASE);
  localparam logic [VEC_W-1:0] NMI_V  = VEC_W'(NMI_VEC);

  logic [NSRC-1:0]  pend;
  logic             nmi_pend;
  logic             found;
  logic [IDX_W-1:0] win_idx;
  lvl_t             win_lvl;

  logic             take;
  logic             take_nmi;
  logic             acc_nx;
  logic             nmi_nx;
  logic [VEC_W-1:0] vec_nx;
  lvl_t             mask_nx;

  irqc_pending #(.NSRC(NSRC)) u_pend (
    .clk(clk), .rst_n(rst_n), .src_event(src_event),
    .src_en(src_en), .src_ack(src_ack), .pend(pend)
  );

  irqc_nmi_edge u_nmi (
    .clk(clk), .rst_n(rst_n), .nmi_in(nmi_in),
    .nmi_taken(take_nmi), .nmi_pend(nmi_pend)
  );

  irqc_arbiter #(.NSRC(NSRC)) u_arb (
    .pend(pend), .prio(src_prio), .found(found),
    .win_idx(win_idx), .win_lvl(win_lvl)
  );

  always_comb begin
    take     = insn_done && !accept && (nmi_pend || (found && win_lvl > mask_lvl));
    take_nmi = take && nmi_pend;
    acc_nx   = take;
    nmi_nx   = take_nmi;
    vec_nx   = '0;
    mask_nx  = '0;
    if (take_nmi) begin
      vec_nx  = NMI_V;
      mask_nx = LVL_TOP;
    end else if (take) begin
      vec_nx  = BASE_V + VEC_W'(win_idx);
      mask_nx = win_lvl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      accept    <= 1'b0;
      acc_nmi   <= 1'b0;
      acc_vec   <= '0;
      new_mask  <= '0;
      trace_clr <= 1'b0;
    end else begin
      accept    <= acc_nx;
      acc_nmi   <= nmi_nx;
      acc_vec   <= vec_nx;
      new_mask  <= mask_nx;
      trace_clr <= acc_nx;
    end
  end

  // R7: acceptance only follows a boundary strobe
  a_r7_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> $past(insn_done));
  // R7: never back to back
  a_r7_single: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !accept);
  // R5: maskable acceptance strictly above the old mask
  a_r5_strict: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !acc_nmi) |-> (new_mask > $past(mask_lvl)));
  // R8: non-maskable forces top level
  a_r8_nmi_top: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && acc_nmi) |-> (new_mask == LVL_TOP && acc_vec == NMI_V));
  // R9: trace pulse coincides with acceptance
  a_r9_trace: assert property (@(posedge clk) disable iff (!rst_n)
    trace_clr == accept);
endmodule

// File: tb/sim_prio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_prio_irq_ctrl;
  localparam int PERIOD = 10;
  localparam int N = 8;
  localparam int VB = 16;
  localparam int NV = 8;

  logic clk = 0, rst_n = 0;
  logic [N-1:0] ev = '0, en = '0, ack = '0;
  logic [3*N-1:0] prio = '0;
  logic nmi = 0, idone = 0;
  logic [2:0] mask = '0;
  logic accept, acc_nmi, trace_clr;
  logic [7:0] acc_vec;
  logic [2:0] new_mask;

  int tests = 0, fails = 0;

  // bench model state
  logic [N-1:0] m_pend = '0;
  logic m_npend = 0, m_nprev = 0, m_acc = 0;
  logic e_acc = 0, e_nmi = 0, e_tr = 0;
  logic [7:0] e_vec = '0;
  logic [2:0] e_mask = '0;

  always #(PERIOD/2) clk = ~clk;

  prio_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .src_event(ev), .src_en(en), .src_ack(ack),
    .src_prio(prio), .nmi_in(nmi), .mask_lvl(mask), .insn_done(idone),
    .accept(accept), .acc_nmi(acc_nmi), .acc_vec(acc_vec),
    .new_mask(new_mask), .trace_clr(trace_clr)
  );

  function automatic int pick(logic [N-1:0] p, logic [3*N-1:0] pr);
    int best = -1;
    for (int i = 0; i < N; i++)
      if (p[i] && (best < 0 || pr[3*i +: 3] > pr[3*best +: 3])) best = i;
    return best;
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // inputs are already applied; predict, clock, compare at negedge
  task automatic step(string tag);
    int w;
    logic take;
    w = pick(m_pend, prio);
    take = idone && !m_acc && (m_npend || (w >= 0 && prio[3*w +: 3] > mask));
    e_acc = take; e_tr = take; e_nmi = take && m_npend;
    e_vec = '0; e_mask = '0;
    if (take && m_npend) begin e_vec = 8'(NV); e_mask = 3'd7; end
    else if (take) begin e_vec = 8'(VB + w); e_mask = prio[3*w +: 3]; end
    for (int i = 0; i < N; i++)
      m_pend[i] = (ack[i] || !en[i]) ? 1'b0 : (m_pend[i] | ev[i]);
    m_npend = (nmi && !m_nprev) || (m_npend && !e_nmi);
    m_nprev = nmi;
    m_acc = e_acc;
    @(posedge clk); @(negedge clk);
    chk({tag, " accept"}, 16'(accept), 16'(e_acc));
    chk({tag, " nmi"}, 16'(acc_nmi), 16'(e_nmi));
    chk({tag, " vector"}, 16'(acc_vec), 16'(e_vec));
    chk({tag, " mask"}, 16'(new_mask), 16'(e_mask));
    chk({tag, " trace"}, 16'(trace_clr), 16'(e_tr));
  endtask

  task automatic idle(string tag, int n);
    ev = '0; ack = '0; idone = 0;
    for (int i = 0; i < n; i++) step(tag);
  endtask

  task automatic clear_all();
    ev = '0; ack = '1; idone = 0; step("clear"); ack = '0;
  endtask

  task automatic setp(int k, int l);
    prio[3*k +: 3] = 3'(l);
  endtask

  initial begin
    #(PERIOD*150000);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d5));
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 accept", 16'(accept), 16'd0);
    chk("R10 vector", 16'(acc_vec), 16'd0);
    chk("R10 trace", 16'(trace_clr), 16'd0);
    rst_n = 1;
    idle("R10", 2);

    // R1: disabled source ignored
    en = '0; setp(2, 5); mask = 0;
    ev = 8'h04; step("R1"); ev = '0; idone = 1; step("R1"); idle("R1", 2);
    chk("R1 no accept", 16'(accept), 16'd0);

    // R3: level ordering
    en = '1; setp(1, 3); setp(5, 6);
    ev = 8'h22; step("R3"); ev = '0; idone = 1; step("R3"); idle("R3", 1);
    clear_all();

    // R4: equal-level tie goes to lower index
    setp(3, 4); setp(6, 4);
    ev = 8'h48; step("R4"); ev = '0; idone = 1; step("R4"); idle("R4", 1);
    clear_all();

    // R5 / R2: at mask level stays pending, accepted after lowering
    setp(0, 4); mask = 4;
    ev = 8'h01; step("R5"); ev = '0; idone = 1; step("R5"); step("R2");
    idle("R2", 3);
    mask = 3; idone = 1; step("R5"); idle("R8", 1);
    idone = 1; step("R2 still pending");
    idone = 0; clear_all(); mask = 0;

    // R6: non-maskable under mask 7 outranks a pending source
    mask = 7; setp(4, 7); ev = 8'h10; nmi = 1; step("R6");
    ev = '0; idone = 1; step("R6"); idle("R6", 1); nmi = 0;
    idone = 1; step("R6 cleared"); idle("R6", 1);
    clear_all(); mask = 0;

    // R7: held strobe gives no back-to-back acceptance
    setp(7, 2); ev = 8'h80; step("R7"); ev = '0;
    idone = 1; step("R7"); step("R7"); step("R7"); idle("R7", 1);
    clear_all();

    // random traffic covering R1..R9
    for (int c = 0; c < 3000; c++) begin
      if (c % 200 == 0)
        for (int k = 0; k < N; k++) setp(k, $urandom_range(0, 7));
      ev    = 8'($urandom) & 8'($urandom);
      ack   = 8'($urandom) & 8'($urandom) & 8'($urandom);
      if ($urandom_range(0, 15) == 0) en = 8'($urandom) | 8'($urandom);
      if ($urandom_range(0, 7) == 0) mask = 3'($urandom);
      if ($urandom_range(0, 31) == 0) nmi = ~nmi;
      idone = ($urandom_range(0, 2) == 0);
      step("R9 random");
    end
    idle("end", 2);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule